// File: doc/BRIEF.md
# Clock Output Gate and Power-Down Sequencer

This block is the control logic of a multi-output clock buffer. It decides, for each differential output and for the single-ended reference output, whether the output runs, holds a static level, or (for the reference only) floats. It takes four kinds of input. The first is a combined power-good / power-down level. The second is one active-low enable pin per output. The third is a set of register bits from the configuration interface. The last is a PLL lock flag. From these it produces registered gate controls that the analog drivers use directly.

The first time power-good is seen high, the block captures its power-up straps. These are a spread-select strap, already decoded from three levels to two bits, and an address-select strap. It exports the captured values for the register interface. Later falls of power-good enter power-down and later rises leave it, with no new strap capture. Every gate change waits for a strobe that marks the low phase of the output clock, so no runt pulse reaches a pin. The asynchronous pins and the power-good level pass through two-flop synchronizers first.

Top module: `clk_gate_seq`

## Requirements
- R1: On the first synchronized high of `pwrgd_i` after reset, `ss_strap_i` and `addr_strap_i` are captured. `addr_sel_o` reports the captured address strap. `ss_cc_o` is 1 when the captured spread strap is not 00. Later power-good highs do not re-capture, and both outputs keep their values.
- R2: Enable pins are active low. In power-good, with the register enable bit at 1 and lock present, `oe_n_i[i]`=0 makes output i run and `oe_n_i[i]`=1 stops it.
- R3: While synchronized power-good is low, every differential output has `dif_run_o`=0, `dif_t_o`=0 and `dif_c_o`=0.
- R4: In power-good, a differential output runs only when its register enable bit is 1, its pin is 0 and `pll_lock_i` is 1. While an output runs, its `dif_t_o` and `dif_c_o` bits are 0.
- R5: In power-good with `reg_oe_i[i]`=0, output i is stopped whatever its pin.
- R6: `ref_hiz_o` is 1, and `ref_run_o` is 0, from reset until the first power-good. After that, `ref_hiz_o` stays 0. In power-good, `ref_run_o` equals `reg_ref_en_i`. In power-down, `ref_run_o` equals `reg_ref_keep_i`.
- R7: A stopped differential output in power-good drives the true leg from `reg_dis_lvl_i[1]` and the complement leg from `reg_dis_lvl_i[0]`. The value 00 gives both legs low.
- R8: With `pll_lock_i`=0, no differential output runs.
- R9: `ss_amt_o` is 00 while `ss_cc_o` is 0, so the register request is ignored. While `ss_cc_o` is 1, `ss_amt_o` follows `reg_ss_amt_i` one cycle later.
- R10: A pin or power-good change made before clock edge k reaches the gate outputs after edge k+2, provided `clk_low_i` is 1 at that edge.
- R11: Gate outputs (`dif_*`, `ref_run_o`, `ref_hiz_o`) change only at edges where `clk_low_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock, same domain as output clock phase strobe |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrgd_i | input | 1 | Asynchronous power-good (1) / power-down (0) level |
| oe_n_i | input | NUM_OUT | Asynchronous active-low per-output enable pins |
| reg_oe_i | input | NUM_OUT | Register enable bit per differential output |
| reg_ref_en_i | input | 1 | Register enable for the reference output in power-good |
| reg_ref_keep_i | input | 1 | Register bit keeping the reference running in power-down |
| reg_dis_lvl_i | input | 2 | Stopped-output leg levels: [1] true, [0] complement |
| reg_ss_amt_i | input | 2 | Requested spread amount within the common-clock family |
| pll_lock_i | input | 1 | PLL lock flag, synchronous to clk_i |
| clk_low_i | input | 1 | Strobe: output clock is low during the coming edge |
| ss_strap_i | input | 2 | Decoded spread strap (00 low, 01 mid, 10 high) |
| addr_strap_i | input | 1 | Address-select strap |
| dif_run_o | output | NUM_OUT | Differential output runs |
| dif_t_o | output | NUM_OUT | True leg static level when not running |
| dif_c_o | output | NUM_OUT | Complement leg static level when not running |
| ref_run_o | output | 1 | Reference output runs |
| ref_hiz_o | output | 1 | Reference output floats |
| addr_sel_o | output | 1 | Captured address strap |
| ss_cc_o | output | 1 | Captured mode: 1 common-clock/SRIS family, 0 non-spread independent |
| ss_amt_o | output | 2 | Spread amount in effect |

## Verification
On every cycle the assertions check four things. Gate outputs move only after a low-phase strobe. Nothing runs without lock, and power-down forces all legs low. The reference never floats again once released. The captured straps never change after start-up, and the non-spread mode never reports a spread amount. Some properties hold across many steps, and only the bench scenarios show them. One is the full per-output truth table over every combination of power-good, lock, register bits, levels and pins. Others are the exact three-edge latency through the synchronizers and the refusal to re-capture straps on a later power-good. The last is that the spread amount follows the register only in the common-clock family.

// File: rtl/clk_gate_seq_pkg.sv
package clk_gate_seq_pkg;
  typedef struct packed {
    logic run;
    logic t;
    logic c;
  } leg_t;

  function automatic leg_t leg_decide(input logic pg, input logic lock,
                                      input logic en_reg, input logic oe_n,
                                      input logic [1:0] lvl);
    leg_t r;
    if (!pg) begin
      r = '{run: 1'b0, t: 1'b0, c: 1'b0};
    end else if (en_reg && !oe_n && lock) begin
      r = '{run: 1'b1, t: 1'b0, c: 1'b0};
    end else begin
      r = '{run: 1'b0, t: lvl[1], c: lvl[0]};
    end
    return r;
  endfunction
endpackage

// File: rtl/clk_gate_seq_sync.sv
module clk_gate_seq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/clk_gate_seq_strap.sv
module clk_gate_seq_strap (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pg_i,
  input  logic [1:0] ss_strap_i,
  input  logic       addr_strap_i,
  input  logic [1:0] reg_ss_amt_i,
  output logic       started_o,
  output logic       addr_sel_o,
  output logic       ss_cc_o,
  output logic [1:0] ss_amt_o
);
  logic       started_q, started_d;
  logic       addr_q, addr_d;
  logic       cc_q, cc_d;
  logic [1:0] amt_q, amt_d;
  logic       cap_en;

  assign cap_en = pg_i && !started_q;

  always_comb begin
    started_d = started_q;
    addr_d    = addr_q;
    cc_d      = cc_q;
    if (cap_en) begin
      started_d = 1'b1;
      addr_d    = addr_strap_i;
      cc_d      = (ss_strap_i != 2'b00);
    end
    amt_d = cc_q ? reg_ss_amt_i : 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      addr_q    <= 1'b0;
      cc_q      <= 1'b0;
      amt_q     <= 2'b00;
    end else begin
      started_q <= started_d;
      addr_q    <= addr_d;
      cc_q      <= cc_d;
      amt_q     <= amt_d;
    end
  end

  assign started_o  = started_q;
  assign addr_sel_o = addr_q;
  assign ss_cc_o    = cc_q;
  assign ss_amt_o   = amt_q;
endmodule

// File: rtl/clk_gate_seq_gate.sv
module clk_gate_seq_gate
  import clk_gate_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       pg_i,
  input  logic       lock_i,
  input  logic       en_reg_i,
  input  logic       oe_n_i,
  input  logic [1:0] lvl_i,
  output logic       run_o,
  output logic       t_o,
  output logic       c_o
);
  leg_t leg_q, leg_d;

  always_comb begin
    leg_d = leg_decide(pg_i, lock_i, en_reg_i, oe_n_i, lvl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q <= '0;
    end else if (upd_i) begin
      leg_q <= leg_d;
    end
  end

  assign run_o = leg_q.run;
  assign t_o   = leg_q.t;
  assign c_o   = leg_q.c;
endmodule

// File: rtl/clk_gate_seq.sv
module clk_gate_seq #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrgd_i,
  input  logic [NUM_OUT-1:0] oe_n_i,
  input  logic [NUM_OUT-1:0] reg_oe_i,
  input  logic               reg_ref_en_i,
  input  logic               reg_ref_keep_i,
  input  logic [1:0]         reg_dis_lvl_i,
  input  logic [1:0]         reg_ss_amt_i,
  input  logic               pll_lock_i,
  input  logic               clk_low_i,
  input  logic [1:0]         ss_strap_i,
  input  logic               addr_strap_i,
  output logic [NUM_OUT-1:0] dif_run_o,
  output logic [NUM_OUT-1:0] dif_t_o,
  output logic [NUM_OUT-1:0] dif_c_o,
  output logic               ref_run_o,
  output logic               ref_hiz_o,
  output logic               addr_sel_o,
  output logic               ss_cc_o,
  output logic [1:0]         ss_amt_o
);
  localparam int SYNC_W = NUM_OUT + 1;

  logic               rst_n_int;
  logic [SYNC_W-1:0]  sync_q;
  logic               pg_s;
  logic [NUM_OUT-1:0] oe_n_s;
  logic               started;
  logic               ref_run_q, ref_run_d;
  logic               ref_hiz_q, ref_hiz_d;

  // reset: asserted asynchronously, released after two clock edges
  clk_gate_seq_sync #(.W(1)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n_int)
  );

  // R10: two-flop synchronizer on the asynchronous pins
  clk_gate_seq_sync #(.W(SYNC_W)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   ({oe_n_i, pwrgd_i}),
    .q_o   (sync_q)
  );

  assign pg_s   = sync_q[0];
  assign oe_n_s = sync_q[SYNC_W-1:1];

  clk_gate_seq_strap u_strap (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .pg_i        (pg_s),
    .ss_strap_i  (ss_strap_i),
    .addr_strap_i(addr_strap_i),
    .reg_ss_amt_i(reg_ss_amt_i),
    .started_o   (started),
    .addr_sel_o  (addr_sel_o),
    .ss_cc_o     (ss_cc_o),
    .ss_amt_o    (ss_amt_o)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    clk_gate_seq_gate u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_int),
      .upd_i   (clk_low_i),
      .pg_i    (pg_s),
      .lock_i  (pll_lock_i),
      .en_reg_i(reg_oe_i[i]),
      .oe_n_i  (oe_n_s[i]),
      .lvl_i   (reg_dis_lvl_i),
      .run_o   (dif_run_o[i]),
      .t_o     (dif_t_o[i]),
      .c_o     (dif_c_o[i])
    );
  end

  // R6: reference output control
  always_comb begin
    ref_hiz_d = !(started || pg_s);
    if (ref_hiz_d) begin
      ref_run_d = 1'b0;
    end else if (pg_s) begin
      ref_run_d = reg_ref_en_i;
    end else begin
      ref_run_d = reg_ref_keep_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ref_run_q <= 1'b0;
      ref_hiz_q <= 1'b1;
    end else if (clk_low_i) begin
      ref_run_q <= ref_run_d;
      ref_hiz_q <= ref_hiz_d;
    end
  end

  assign ref_run_o = ref_run_q;
  assign ref_hiz_o = ref_hiz_q;
endmodule

// File: rtl/clk_gate_seq_chk.sv
module clk_gate_seq_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pg_s,
  input logic               pll_lock_i,
  input logic               clk_low_i,
  input logic [NUM_OUT-1:0] dif_run_o,
  input logic [NUM_OUT-1:0] dif_t_o,
  input logic [NUM_OUT-1:0] dif_c_o,
  input logic               ref_run_o,
  input logic               ref_hiz_o,
  input logic               addr_sel_o,
  input logic               ss_cc_o,
  input logic [1:0]         ss_amt_o
);
  p_gate_at_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clk_low_i) |-> ($stable(dif_run_o) && $stable(dif_t_o) &&
                           $stable(dif_c_o) && $stable(ref_run_o) && $stable(ref_hiz_o)));

  p_no_run_unlocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clk_low_i) && !$past(pll_lock_i)) |-> (dif_run_o == '0));

  p_pd_legs_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clk_low_i) && !$past(pg_s)) |->
      (dif_run_o == '0 && dif_t_o == '0 && dif_c_o == '0));

  p_ref_hiz_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_hiz_o) |-> !ref_hiz_o);

  p_ref_hiz_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_hiz_o |-> !ref_run_o);

  p_strap_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ref_hiz_o) |-> ($stable(addr_sel_o) && $stable(ss_cc_o)));

  p_srns_no_amt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ss_cc_o) |-> (ss_amt_o == 2'b00));
endmodule

bind clk_gate_seq clk_gate_seq_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pg_s      (pg_s),
  .pll_lock_i(pll_lock_i),
  .clk_low_i (clk_low_i),
  .dif_run_o (dif_run_o),
  .dif_t_o   (dif_t_o),
  .dif_c_o   (dif_c_o),
  .ref_run_o (ref_run_o),
  .ref_hiz_o (ref_hiz_o),
  .addr_sel_o(addr_sel_o),
  .ss_cc_o   (ss_cc_o),
  .ss_amt_o  (ss_amt_o)
);

// File: tb/clk_gate_seq_test.sv
module clk_gate_seq_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pwrgd;
  logic [N-1:0] oe_n, reg_oe;
  logic         ref_en, ref_keep, lock, clk_low, addr_strap;
  logic [1:0]   dis_lvl, ss_req, ss_strap;
  logic [N-1:0] run, tl, cl;
  logic         ref_run, ref_hiz, addr_sel, ss_cc;
  logic [1:0]   ss_amt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  clk_gate_seq #(.NUM_OUT(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwrgd_i(pwrgd), .oe_n_i(oe_n),
    .reg_oe_i(reg_oe), .reg_ref_en_i(ref_en), .reg_ref_keep_i(ref_keep),
    .reg_dis_lvl_i(dis_lvl), .reg_ss_amt_i(ss_req), .pll_lock_i(lock),
    .clk_low_i(clk_low), .ss_strap_i(ss_strap), .addr_strap_i(addr_strap),
    .dif_run_o(run), .dif_t_o(tl), .dif_c_o(cl), .ref_run_o(ref_run),
    .ref_hiz_o(ref_hiz), .addr_sel_o(addr_sel), .ss_cc_o(ss_cc), .ss_amt_o(ss_amt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic power_on(input logic [1:0] ss, input logic adr);
    rst_n = 1'b0; pwrgd = 1'b0; oe_n = '1; reg_oe = '0; ref_en = 1'b0;
    ref_keep = 1'b0; lock = 1'b0; clk_low = 1'b1; dis_lvl = 2'b00;
    ss_req = 2'b00; ss_strap = ss; addr_strap = adr;
    settle(3);
    rst_n = 1'b1;
    settle(4);
  endtask

  initial begin
    power_on(2'b00, 1'b1);
    check("R6 reset hiz", ref_hiz, 1);
    check("R6 reset ref_run", ref_run, 0);
    check("R3 reset legs", {run, tl, cl}, 0);
    check("R1 reset addr", addr_sel, 0);

    ref_keep = 1'b1; ref_en = 1'b1;
    settle(5);
    check("R6 hiz before first power-good", {ref_hiz, ref_run}, 2'b10);

    ss_req = 2'b11; pwrgd = 1'b1;
    settle(5);
    check("R1 addr captured", addr_sel, 1);
    check("R1 mode non-spread", ss_cc, 0);
    check("R9 amount ignored in non-spread", ss_amt, 0);
    check("R6 hiz released", {ref_hiz, ref_run}, 2'b01);

    ss_strap = 2'b10; addr_strap = 1'b0; pwrgd = 1'b0;
    settle(5);
    check("R6 ref kept running in power-down", {ref_hiz, ref_run}, 2'b01);
    ref_keep = 1'b0;
    settle(5);
    check("R6 ref stopped in power-down", {ref_hiz, ref_run}, 2'b00);
    pwrgd = 1'b1;
    settle(5);
    check("R1 no re-capture addr", addr_sel, 1);
    check("R1 no re-capture mode", ss_cc, 0);

    // R10 latency
    reg_oe = '1; lock = 1'b1; oe_n = '1;
    settle(5);
    oe_n = 4'b1110;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 not yet after two edges", run, 4'b0000);
    settle(1);
    check("R10 visible after third edge", run, 4'b0001);

    // R11 hold while clock phase is high
    clk_low = 1'b0; oe_n = '1;
    settle(6);
    check("R11 held without low strobe", run, 4'b0001);
    clk_low = 1'b1;
    settle(1);
    check("R11 applied at low strobe", run, 4'b0000);

    // R8 no lock
    oe_n = '0; lock = 1'b0; dis_lvl = 2'b11;
    settle(5);
    check("R8 no run without lock", {run, tl, cl}, {4'h0, 4'hF, 4'hF});
    dis_lvl = 2'b00;
    settle(5);
    check("R7 default level both low", {run, tl, cl}, 12'h000);

    // exhaustive sweep: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < (1 << 14); v++) begin
      logic [13:0] s;
      logic [N-1:0] er, et, ec;
      logic exr;
      s = v[13:0];
      pwrgd = s[0]; lock = s[1]; ref_keep = s[2]; ref_en = s[3];
      dis_lvl = s[5:4]; reg_oe = s[9:6]; oe_n = s[13:10];
      for (int i = 0; i < N; i++) begin
        if (!s[0]) begin
          er[i] = 0; et[i] = 0; ec[i] = 0;
        end else if (s[6+i] && !s[10+i] && s[1]) begin
          er[i] = 1; et[i] = 0; ec[i] = 0;
        end else begin
          er[i] = 0; et[i] = s[5]; ec[i] = s[4];
        end
      end
      exr = s[0] ? s[3] : s[2];
      settle(3);
      check("R2 R3 R4 R5 R6 R7 R8 sweep", {run, tl, cl, ref_run, ref_hiz},
            {er, et, ec, exr, 1'b0});
    end

    // second power cycle in the common-clock family
    power_on(2'b01, 1'b0);
    ss_req = 2'b10; pwrgd = 1'b1;
    settle(5);
    check("R1 mid strap selects common-clock", ss_cc, 1);
    check("R1 addr captured low", addr_sel, 0);
    check("R9 amount follows register", ss_amt, 2'b10);
    ss_req = 2'b01;
    settle(2);
    check("R9 amount changed in family", ss_amt, 2'b01);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule